// File: doc/BRIEF.md
# Hash Digest Readout Bank

This block sits between a hash engine and a simple memory-mapped bus with wait states. It keeps eight 32-bit digest words. A done strobe from the engine loads all eight words in one cycle. Bus masters read them back through two address windows. The short window reaches only the five leading words. The extended window reaches all eight, so the five leading words can be read from either place.

The algorithm select input decides how many words are meaningful. Words beyond that count read as zero. A start request marks the engine busy. A read that hits a digest address while the engine is busy is held with `ready_o` low until the done strobe arrives. It then returns the fresh digest. Reads to any other address complete at once with zero. Writes are accepted and discarded.

Top module: `hash_dgst_bank`

## Requirements
- R1: After reset all stored words are 0x00000000 and the engine is not busy. Every digest read then returns zero with `ready_o` high in the same cycle.
- R2: The short window maps word k (k = 0..4) to address 0x00C + 4*k. A read there returns that word in the cycle `rd_en_i` is high, with `ready_o` high, provided the engine is idle.
- R3: The extended window maps word k (k = 0..7) to address 0x310 + 4*k. Words 0..4 there return the same data as the short window.
- R4: `alg_i` encoding: 2'b00 = SHA-1 (5 valid words), 2'b01 = MD5 (4 valid words), 2'b10 = SHA-224 (7 valid words), 2'b11 = SHA-256 (8 valid words). A read of a word index at or beyond the valid count returns zero.
- R5: A `start_i` pulse makes the engine busy from the next cycle. A read that hits a digest address while busy keeps `ready_o` low and `rdata_o` zero. It completes in the cycle after `done_i`, with the newly loaded data.
- R6: `done_i` loads all eight words of `digest_i` together (word k taken from bits [32k+31:32k]) and clears busy from the next cycle.
- R7: A read of any address outside both windows, including misaligned addresses, returns zero with `ready_o` high in the same cycle, even while busy.
- R8: A write (`wr_en_i` high, `rd_en_i` low) gets `ready_o` high and leaves every stored word unchanged.
- R9: When `start_i` and `done_i` are high in the same cycle, the words load and the engine stays busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alg_i | input | 2 | Algorithm select |
| start_i | input | 1 | Digest calculation request |
| done_i | input | 1 | Calculation finished, load digest |
| digest_i | input | 256 | Digest words from the engine |
| rd_en_i | input | 1 | Bus read strobe |
| wr_en_i | input | 1 | Bus write strobe |
| addr_i | input | 12 | Bus byte address |
| rdata_o | output | 32 | Read data, valid when ready_o is high |
| ready_o | output | 1 | Transfer completes this cycle |

## Verification
Random reads cover digest addresses in both windows, unmapped and misaligned addresses, and all four algorithm codes. This separates the two window decoders, the per-algorithm zero masking and the fallback for undecoded addresses. Random start and done pulses, including ones that coincide, show whether busy is set and cleared in the right order. Directed stall sequences hold a read across a whole calculation and check that it completes with the new digest, not the old one. Interleaved writes show that the stored words never change except on done.

// File: rtl/hash_dgst_pkg.sv
package hash_dgst_pkg;
  localparam int DW = 32;
  localparam int NW = 8;
  localparam int AW = 12;

  typedef enum logic [1:0] {
    ALG_SHA1   = 2'b00,
    ALG_MD5    = 2'b01,
    ALG_SHA224 = 2'b10,
    ALG_SHA256 = 2'b11
  } alg_e;

  function automatic int valid_words(alg_e a);
    case (a)
      ALG_SHA1:   return 5;
      ALG_MD5:    return 4;
      ALG_SHA224: return 7;
      default:    return 8;
    endcase
  endfunction
endpackage

// File: rtl/hash_dgst_decode.sv
module hash_dgst_decode #(
  parameter int AW         = 12,
  parameter int NW         = 8,
  parameter int SHORT_N    = 5,
  parameter int SHORT_BASE = 'h00C,
  parameter int EXT_BASE   = 'h310,
  localparam int IW        = $clog2(NW)
) (
  input  logic [AW-1:0] addr_i,
  output logic          hit_o,
  output logic [IW-1:0] idx_o
);
  logic [NW-1:0] hit_vec;

  for (genvar k = 0; k < NW; k++) begin : g_word
    if (k < SHORT_N) begin : g_both
      assign hit_vec[k] = (addr_i == AW'(EXT_BASE + 4*k)) ||
                          (addr_i == AW'(SHORT_BASE + 4*k));
    end else begin : g_ext
      assign hit_vec[k] = (addr_i == AW'(EXT_BASE + 4*k));
    end
  end

  always_comb begin
    idx_o = '0;
    for (int k = 0; k < NW; k++)
      if (hit_vec[k]) idx_o = IW'(k);
  end

  assign hit_o = |hit_vec;
endmodule

// File: rtl/hash_dgst_store.sv
module hash_dgst_store #(
  parameter int DW = 32,
  parameter int NW = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             done_i,
  input  logic [NW*DW-1:0] digest_i,
  output logic [NW*DW-1:0] words_o,
  output logic             busy_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      words_o <= '0;
      busy_o  <= 1'b0;
    end else begin
      if (done_i) words_o <= digest_i;
      // a new request wins over a finishing one
      if (start_i)     busy_o <= 1'b1;
      else if (done_i) busy_o <= 1'b0;
    end
  end

  AST_BUSY_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o); // R5
  AST_BUSY_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && !start_i |=> !busy_o); // R6
  AST_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> words_o == $past(digest_i)); // R6
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |=> $stable(words_o)); // R8
endmodule

// File: rtl/hash_dgst_bank.sv
module hash_dgst_bank
  import hash_dgst_pkg::*;
#(
  parameter int DW         = hash_dgst_pkg::DW,
  parameter int NW         = hash_dgst_pkg::NW,
  parameter int AW         = hash_dgst_pkg::AW,
  parameter int SHORT_N    = 5,
  parameter int SHORT_BASE = 'h00C,
  parameter int EXT_BASE   = 'h310,
  localparam int IW        = $clog2(NW)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       alg_i,
  input  logic             start_i,
  input  logic             done_i,
  input  logic [NW*DW-1:0] digest_i,
  input  logic             rd_en_i,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    addr_i,
  output logic [DW-1:0]    rdata_o,
  output logic             ready_o
);
  logic             hit, busy, stall, in_range;
  logic [IW-1:0]    idx;
  logic [NW*DW-1:0] words;

  hash_dgst_decode #(
    .AW(AW), .NW(NW), .SHORT_N(SHORT_N),
    .SHORT_BASE(SHORT_BASE), .EXT_BASE(EXT_BASE)
  ) u_dec (
    .addr_i(addr_i), .hit_o(hit), .idx_o(idx)
  );

  hash_dgst_store #(.DW(DW), .NW(NW)) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .done_i(done_i),
    .digest_i(digest_i), .words_o(words), .busy_o(busy)
  );

  assign stall    = rd_en_i && hit && busy;
  assign in_range = int'(idx) < valid_words(alg_e'(alg_i));
  assign ready_o  = rd_en_i ? !stall : wr_en_i;
  assign rdata_o  = (rd_en_i && hit && !busy && in_range) ? words[idx*DW +: DW] : '0;

  AST_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && hit && busy |-> !ready_o && rdata_o == '0); // R5
  AST_UNDEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && !hit |-> ready_o && rdata_o == '0); // R7
  AST_UNUSED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && hit && !in_range |-> rdata_o == '0); // R4
  AST_WR_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !rd_en_i |-> ready_o); // R8
endmodule

// File: tb/hash_dgst_bank_tb.sv
module hash_dgst_bank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 8;
  localparam int DW = 32;

  logic clk = 0, rst_n = 0;
  logic [1:0] alg = 0;
  logic start = 0, done = 0, rd_en = 0, wr_en = 0;
  logic [NW*DW-1:0] digest = '0;
  logic [11:0] addr = '0;
  logic [31:0] rdata;
  logic ready;

  int n_chk = 0, n_fail = 0;
  logic [NW*DW-1:0] m_words = '0;
  logic m_busy = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hash_dgst_bank dut_i (
    .clk_i(clk), .rst_ni(rst_n), .alg_i(alg), .start_i(start), .done_i(done),
    .digest_i(digest), .rd_en_i(rd_en), .wr_en_i(wr_en), .addr_i(addr),
    .rdata_o(rdata), .ready_o(ready)
  );

  function automatic int word_of(logic [11:0] a);
    for (int k = 0; k < 8; k++) if (a == 12'h310 + 12'(4*k)) return k;
    for (int k = 0; k < 5; k++) if (a == 12'h00C + 12'(4*k)) return k;
    return -1;
  endfunction

  function automatic int nvalid(logic [1:0] a);
    return (a == 2'b00) ? 5 : (a == 2'b01) ? 4 : (a == 2'b10) ? 7 : 8;
  endfunction

  function automatic logic [32:0] exp_out(logic [11:0] a, logic [1:0] al,
                                          logic [NW*DW-1:0] w, logic b,
                                          logic rd, logic wr);
    int k = word_of(a);
    if (!rd) return {wr, 32'h0};
    if (k < 0) return {1'b1, 32'h0};
    if (b) return {1'b0, 32'h0};
    if (k >= nvalid(al)) return {1'b1, 32'h0};
    return {1'b1, w[k*DW +: DW]};
  endfunction

  task automatic check(string req);
    logic [32:0] e = exp_out(addr, alg, m_words, m_busy, rd_en, wr_en);
    n_chk++;
    if ({ready, rdata} !== e) begin
      n_fail++;
      $display("FAIL %s addr=%h alg=%0d act ready=%b data=%h exp ready=%b data=%h",
               req, addr, alg, ready, rdata, e[32], e[31:0]);
    end
  endtask

  // inputs already driven after negedge; check, then advance one edge
  task automatic step(string req);
    #1 check(req);
    @(posedge clk);
    if (done) m_words = digest;
    if (start) m_busy = 1; else if (done) m_busy = 0;
    @(negedge clk);
    start = 0; done = 0; rd_en = 0; wr_en = 0;
  endtask

  task automatic rd(logic [11:0] a, string req);
    rd_en = 1; addr = a; step(req);
  endtask

  function automatic logic [NW*DW-1:0] rnd_digest();
    logic [NW*DW-1:0] d;
    for (int k = 0; k < NW; k++) d[k*DW +: DW] = $urandom;
    return d;
  endfunction

  function automatic logic [11:0] rnd_addr();
    case ($urandom % 5)
      0: return 12'h00C + 12'(4 * ($urandom % 5));
      1, 2: return 12'h310 + 12'(4 * ($urandom % 8));
      3: return 12'h310 + 12'($urandom % 32);
      default: return 12'($urandom);
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    for (int k = 0; k < 8; k++) rd(12'h310 + 12'(4*k), "R1");
    alg = 2'b11;
    for (int k = 0; k < 5; k++) rd(12'h00C + 12'(4*k), "R1");

    // R6: load known digest
    for (int k = 0; k < NW; k++) digest[k*DW +: DW] = 32'hA0B0_0000 + 32'(k);
    done = 1; step("R6");
    for (int k = 0; k < 5; k++) begin
      rd(12'h00C + 12'(4*k), "R2");
      rd(12'h310 + 12'(4*k), "R3");
    end
    // R4: each algorithm, all eight words
    for (int al = 0; al < 4; al++) begin
      alg = 2'(al);
      for (int k = 0; k < 8; k++) rd(12'h310 + 12'(4*k), "R4");
    end
    // R7: unmapped, gap, misaligned
    rd(12'h000, "R7"); rd(12'h020, "R7"); rd(12'h311, "R7"); rd(12'h330, "R7");
    rd(12'h00E, "R7");
    // R8: writes to every digest address
    for (int k = 0; k < 8; k++) begin
      wr_en = 1; addr = 12'h310 + 12'(4*k); step("R8");
    end
    for (int k = 0; k < 8; k++) rd(12'h310 + 12'(4*k), "R8");

    // R5: read held across calculation
    alg = 2'b11;
    start = 1; rd_en = 1; addr = 12'h314; step("R5");
    for (int i = 0; i < 4; i++) rd(12'h314, "R5");
    rd(12'h400, "R7");
    digest = rnd_digest();
    done = 1; rd_en = 1; addr = 12'h314; step("R5");
    rd(12'h314, "R5");
    rd(12'h018, "R5");

    // R9: start and done together
    start = 1; step("R9");
    digest = rnd_digest();
    start = 1; done = 1; step("R9");
    rd(12'h310, "R9");
    done = 1; step("R9");
    rd(12'h310, "R9"); rd(12'h32C, "R9");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      alg = 2'($urandom);
      if ($urandom % 10 == 0) start = 1;
      if ($urandom % 6 == 0) begin done = 1; digest = rnd_digest(); end
      case ($urandom % 4)
        0: wr_en = 1;
        1: ;
        default: rd_en = 1;
      endcase
      addr = rnd_addr();
      step("R4");
    end

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule